// File: doc/BRIEF.md
# Byte-stream register command bridge

This block sits between a byte-oriented serial target (an I2C or UART receiver and transmitter) and an internal 32-bit register bus. Incoming bytes arrive on a valid/ready stream and are assembled into framed commands. Each command frame opens with a start marker and closes with an end marker. Between them it carries an opcode, a 16-bit word address and, for writes, four data bytes with the most significant byte first. The parser supports three commands: read, write and core reset.

A well-formed read or write makes exactly one access on a simple memory-mapped bus (chip-select, write-enable, address, write data, read data). A well-formed reset makes one pulse on a core reset output. The block then sends a framed response, one byte at a time, on an outgoing valid/ready stream. Responses carry their own start and end markers, a status code and an echo of the address. A read response also carries the data. Unknown opcodes and frames with a bad end marker each get a short error response, and neither touches the bus.

Back-pressure rules are as follows. An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the end of a command until its response has been fully sent. On the output side, `out_valid` stays high and `out_data` holds steady until a cycle with `out_ready` high takes the byte. The bus is single-cycle: `bus_cs` is high for one cycle, and `bus_rdata` must be valid in the cycle that follows a read strobe.

Top module: `regcmd_bridge`

## Requirements
- R1: While waiting for a frame, any input byte other than 0x55 is accepted and discarded. It produces no bus access, no reset pulse and no output.
- R2: The read frame is 0x55, 0x10, addr high, addr low, 0xAA. It makes one bus read (`bus_we`=0) at that address and returns 0xAA, 0x7F, addr high, addr low, the four read-data bytes (most significant first), then 0x55.
- R3: The write frame is 0x55, 0x11, addr high, addr low, four data bytes (most significant first), 0xAA. It makes one single-cycle bus write of that 32-bit word and returns 0xAA, 0x7E, addr high, addr low, 0x55.
- R4: The reset frame is 0x55, 0x01, 0xAA. It raises `core_rst` for exactly one cycle and returns 0xAA, 0x7D, 0x55.
- R5: An opcode other than 0x10, 0x11 or 0x01 returns 0xAA, 0xFE, the opcode, 0x55, right after the opcode byte. It makes no bus access and no reset pulse.
- R6: A byte other than 0xAA in the end position returns 0xAA, 0xFD, the opcode, 0x55. It makes no bus access and no reset pulse.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `in_ready` is low in every cycle in which `out_valid` is high.
- R9: Timing is counted from the edge that accepts the end byte. The bus strobe or reset pulse comes in the next cycle, and the first response byte is valid two cycles after that edge. An error response is valid one cycle after the edge that accepted the offending byte.
- R10: After reset, `out_valid`, `bus_cs` and `core_rst` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Bridge can take an input byte |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer takes the response byte |
| bus_cs | output | 1 | Register bus select, one cycle per access |
| bus_we | output | 1 | Register bus write enable |
| bus_addr | output | 16 | Register bus word address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid the cycle after a read select |
| core_rst | output | 1 | One-cycle reset pulse to the cores |

## Verification
The bench notes the cycle count at the edge that takes the end byte, or the opcode byte for an unknown command. It then checks the cycle in which `out_valid` first rises: two cycles later for a good command, one cycle later for an error response. The check samples on the falling edge, so the rise is seen in the cycle it lands in. A scoreboard compares each bus strobe and each response byte in the cycle its handshake completes, which keeps the byte checks correct under back-pressure. A held byte must still be unchanged on the next falling edge.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam int DATA_BYTES = DATA_W / 8;

  localparam logic [7:0] CMD_SOF  = 8'h55;
  localparam logic [7:0] CMD_EOF  = 8'hAA;
  localparam logic [7:0] OP_READ  = 8'h10;
  localparam logic [7:0] OP_WRITE = 8'h11;
  localparam logic [7:0] OP_RESET = 8'h01;

  localparam logic [7:0] RSP_SOF  = 8'hAA;
  localparam logic [7:0] RSP_EOF  = 8'h55;
  localparam logic [7:0] ST_READ  = 8'h7F;
  localparam logic [7:0] ST_WRITE = 8'h7E;
  localparam logic [7:0] ST_RESET = 8'h7D;
  localparam logic [7:0] ST_UNK   = 8'hFE;
  localparam logic [7:0] ST_BAD   = 8'hFD;

  typedef enum logic [2:0] {
    RK_READ, RK_WRITE, RK_RESET, RK_UNKNOWN, RK_BADEND
  } rsp_kind_e;

  typedef struct packed {
    rsp_kind_e         kind;
    logic [7:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } rsp_t;
endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
  import regcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              bus_cs,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              core_rst,
  output logic              rsp_load,
  output rsp_t              rsp,
  input  logic              rsp_busy
);
  localparam int CNT_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  typedef enum logic [3:0] {
    P_IDLE, P_OP, P_AHI, P_ALO, P_DATA, P_TAIL, P_ACCESS, P_SETTLE, P_REPLY
  } pstate_e;

  pstate_e           state;
  rsp_kind_e         kind;
  logic [7:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [CNT_W-1:0]  cnt;
  logic              accept;

  assign in_ready = (state == P_IDLE) || (state == P_OP) || (state == P_AHI) ||
                    (state == P_ALO) || (state == P_DATA) || (state == P_TAIL);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= P_IDLE;
      kind  <= RK_READ;
      op    <= '0;
      addr  <= '0;
      wdata <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        P_IDLE: if (accept && in_data == CMD_SOF) state <= P_OP;
        P_OP: if (accept) begin
          op <= in_data;
          if (in_data == OP_READ || in_data == OP_WRITE) state <= P_AHI;
          else if (in_data == OP_RESET) state <= P_TAIL;
          else begin
            kind  <= RK_UNKNOWN;
            state <= P_SETTLE;
          end
        end
        P_AHI: if (accept) begin
          addr[ADDR_W-1:8] <= in_data;
          state <= P_ALO;
        end
        P_ALO: if (accept) begin
          addr[7:0] <= in_data;
          cnt       <= '0;
          state     <= (op == OP_WRITE) ? P_DATA : P_TAIL;
        end
        P_DATA: if (accept) begin
          wdata <= {wdata[DATA_W-9:0], in_data};
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(DATA_BYTES - 1)) state <= P_TAIL;
        end
        P_TAIL: if (accept) begin
          if (in_data == CMD_EOF) begin
            kind  <= (op == OP_READ) ? RK_READ : (op == OP_WRITE) ? RK_WRITE : RK_RESET;
            state <= P_ACCESS;
          end else begin
            kind  <= RK_BADEND;
            state <= P_SETTLE;
          end
        end
        P_ACCESS: state <= P_SETTLE;
        P_SETTLE: state <= P_REPLY;
        P_REPLY:  if (!rsp_busy) state <= P_IDLE;
        default:  state <= P_IDLE;
      endcase
    end
  end

  assign bus_cs    = (state == P_ACCESS) && (kind == RK_READ || kind == RK_WRITE);
  assign bus_we    = (kind == RK_WRITE);
  assign bus_addr  = addr;
  assign bus_wdata = wdata;
  assign core_rst  = (state == P_ACCESS) && (kind == RK_RESET);

  assign rsp_load  = (state == P_SETTLE);
  assign rsp.kind  = kind;
  assign rsp.op    = op;
  assign rsp.addr  = addr;
  assign rsp.data  = bus_rdata;

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |=> !bus_cs); // R3
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst); // R4
  AST_BADEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_TAIL && accept && in_data != CMD_EOF) |=> (!bus_cs && !core_rst)); // R6
  AST_IDLE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_IDLE && accept && in_data != CMD_SOF) |=> (in_ready && !bus_cs)); // R1
endmodule

// File: rtl/regcmd_tx.sv
module regcmd_tx
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rsp_load,
  input  rsp_t       rsp,
  output logic       busy,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam int IDX_W = $clog2(DATA_BYTES + 6);

  rsp_t             held;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last;
  logic             active;

  always_comb begin
    case (held.kind)
      RK_READ:  last = IDX_W'(DATA_BYTES + 4);
      RK_WRITE: last = IDX_W'(4);
      RK_RESET: last = IDX_W'(2);
      default:  last = IDX_W'(3);
    endcase
  end

  always_comb begin
    int k;
    k = int'(idx) - 4;
    if (idx == '0) out_data = RSP_SOF;
    else if (idx == last) out_data = RSP_EOF;
    else if (idx == IDX_W'(1)) begin
      case (held.kind)
        RK_READ:    out_data = ST_READ;
        RK_WRITE:   out_data = ST_WRITE;
        RK_RESET:   out_data = ST_RESET;
        RK_UNKNOWN: out_data = ST_UNK;
        default:    out_data = ST_BAD;
      endcase
    end else if (held.kind == RK_UNKNOWN || held.kind == RK_BADEND) out_data = held.op;
    else if (idx == IDX_W'(2)) out_data = held.addr[ADDR_W-1:8];
    else if (idx == IDX_W'(3)) out_data = held.addr[7:0];
    else out_data = 8'(held.data >> (8 * (DATA_BYTES - 1 - k)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else if (rsp_load && !active) begin
      held   <= rsp;
      idx    <= '0;
      active <= 1'b1;
    end else if (active && out_ready) begin
      if (idx == last) active <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  assign out_valid = active;
  assign busy      = active;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_FRAME_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == RSP_SOF)); // R2
endmodule

// File: rtl/regcmd_bridge.sv
module regcmd_bridge
  import regcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              bus_cs,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              core_rst
);
  logic rsp_load;
  logic rsp_busy;
  rsp_t rsp;

  regcmd_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst(core_rst),
    .rsp_load(rsp_load), .rsp(rsp), .rsp_busy(rsp_busy)
  );

  regcmd_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .rsp_load(rsp_load), .rsp(rsp), .busy(rsp_busy),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && core_rst)); // R9
endmodule

// File: tb/regcmd_bridge_tb.sv
module regcmd_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        bus_cs, bus_we, core_rst;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  always #5 clk = ~clk;

  regcmd_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_rst(core_rst)
  );

  logic [31:0] mem [16];
  always @(posedge clk) begin
    if (bus_cs && !bus_we) bus_rdata <= mem[bus_addr[3:0]];
    if (bus_cs && bus_we) mem[bus_addr[3:0]] <= bus_wdata;
  end

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]  exp_q[$];
  logic [48:0] bus_q[$];
  string cur_req = "R10";
  int  rst_seen = 0, r8_bad = 0, tail_cyc = 0, exp_lat = 0;
  bit  lat_pending = 0, bp_en = 0, held_pending = 0, prev_valid = 0;
  logic [7:0] held_byte;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = bp_en ? (cyc % 3 == 0) : 1'b1;
      if (held_pending && out_valid) chk(out_data == held_byte, "R7", out_data, held_byte);
      held_pending = 0;
      if (out_valid && !prev_valid && lat_pending) begin
        chk(cyc - tail_cyc == exp_lat, "R9", cyc - tail_cyc, exp_lat);
        lat_pending = 0;
      end
      if (out_valid && in_ready) r8_bad++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, cur_req, out_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, cur_req, out_data, e);
        end
      end else if (out_valid) begin
        held_pending = 1;
        held_byte = out_data;
      end
      if (bus_cs) begin
        if (bus_q.size() == 0) chk(0, cur_req, {bus_we, bus_addr, bus_wdata}, 0);
        else begin
          logic [48:0] b;
          logic [48:0] a;
          b = bus_q.pop_front();
          a = {bus_we, bus_addr, (bus_we ? bus_wdata : 32'h0)};
          chk(a == b, cur_req, a, b);
        end
      end
      if (core_rst) rst_seen++;
      prev_valid = out_valid;
    end
  end

  task automatic send_byte(logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic arm_latency(int lat);
    tail_cyc = cyc;
    exp_lat = lat;
    lat_pending = 1;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(logic [15:0] a, logic [31:0] d);
    exp_q.push_back(8'hAA); exp_q.push_back(8'h7E);
    exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]); exp_q.push_back(8'h55);
    bus_q.push_back({1'b1, a, d});
    send_byte(8'h55); send_byte(8'h11); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int i = 3; i >= 0; i--) send_byte(d[8*i +: 8]);
    send_byte(8'hAA);
    arm_latency(2);
    wait_done();
  endtask

  task automatic do_read(logic [15:0] a, logic [31:0] d);
    exp_q.push_back(8'hAA); exp_q.push_back(8'h7F);
    exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
    for (int i = 3; i >= 0; i--) exp_q.push_back(d[8*i +: 8]);
    exp_q.push_back(8'h55);
    bus_q.push_back({1'b0, a, 32'h0});
    send_byte(8'h55); send_byte(8'h10); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(8'hAA);
    arm_latency(2);
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 0, "R10", out_valid, 0);
    chk(in_ready == 1, "R10", in_ready, 1);
    chk(bus_cs == 0, "R10", bus_cs, 0);
    chk(core_rst == 0, "R10", core_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: noise discarded
    cur_req = "R1";
    send_byte(8'h00); send_byte(8'hAA); send_byte(8'h13);
    @(negedge clk);
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(in_ready == 1, "R1", in_ready, 1);

    cur_req = "R3";
    do_write(16'h0003, 32'hDEADBEEF);
    cur_req = "R2";
    bp_en = 1;
    do_read(16'h0003, 32'hDEADBEEF);
    cur_req = "R3";
    do_write(16'h1205, 32'h01234567);
    cur_req = "R2";
    do_read(16'h1205, 32'h01234567);
    bp_en = 0;

    // R4: reset command
    cur_req = "R4";
    exp_q.push_back(8'hAA); exp_q.push_back(8'h7D); exp_q.push_back(8'h55);
    send_byte(8'h55); send_byte(8'h01); send_byte(8'hAA);
    arm_latency(2);
    wait_done();
    chk(rst_seen == 1, "R4", rst_seen, 1);

    // R5: unknown opcode
    cur_req = "R5";
    exp_q.push_back(8'hAA); exp_q.push_back(8'hFE); exp_q.push_back(8'h22); exp_q.push_back(8'h55);
    send_byte(8'h55); send_byte(8'h22);
    arm_latency(1);
    wait_done();

    // R6: bad end marker on read and on write
    cur_req = "R6";
    exp_q.push_back(8'hAA); exp_q.push_back(8'hFD); exp_q.push_back(8'h10); exp_q.push_back(8'h55);
    send_byte(8'h55); send_byte(8'h10); send_byte(8'h00); send_byte(8'h01); send_byte(8'h33);
    arm_latency(1);
    wait_done();
    exp_q.push_back(8'hAA); exp_q.push_back(8'hFD); exp_q.push_back(8'h11); exp_q.push_back(8'h55);
    send_byte(8'h55); send_byte(8'h11); send_byte(8'h00); send_byte(8'h03);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h00);
    arm_latency(1);
    wait_done();
    do_read(16'h0003, 32'hDEADBEEF);  // R6: memory untouched

    chk(bus_q.size() == 0, "R6", bus_q.size(), 0);
    chk(rst_seen == 1, "R5", rst_seen, 1);
    chk(r8_bad == 0, "R8", r8_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule